// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one general-purpose timer channel with a 32-bit up-counter. The counter advances on a tick made from one of three clock sources (every system clock, every sixteenth system clock, or rising edges of an external timer pin after a two-flop synchronizer), thinned by an 8-bit prescaler. The same timer pin can also be watched for capture events on a chosen edge. When a capture edge arrives, the counter value is latched.

A reference register is compared with the counter on every tick. A match sets an event flag and can drive the output pin, either as a pulse or as a toggle. In restart mode a match also returns the counter to zero. Each of the two event kinds can be routed to the interrupt line or to a DMA request line, or to neither. The DMA request is held until it is acknowledged.

Software reaches the channel through a small register port. The port has a write strobe with address and data, and a combinational read mux.

Top module: `capcmp_timer`

## Requirements
- R1: After reset every readable register (mode at address 0, reference at 1, capture at 2, event at 3, count at 4) reads zero, and tmr_out, irq and dreq are low.
- R2: The mode bits [2:1] select the tick source: 00 every clock, 01 one clock in sixteen, 10 rising edges of tmr_in seen through two synchronizer flops, 11 no source. Mode bit 0 clear also stops all ticks.
- R3: The prescaler value in mode bits [19:12], written N, passes one source tick in N+1 to the counter.
- R4: Each tick adds one to the count. In free-run mode the count wraps from all ones to zero.
- R5: A tick that arrives while the count equals the reference register sets event bit 1. If mode bit 3 (restart) is set, that tick loads zero into the count instead of incrementing it.
- R6: Mode bits [5:4] set the output pin. 00 or 11 holds it low. 01 drives it high on a match tick and low on the next tick without a match. 10 inverts it on each match.
- R7: Mode bits [7:6] select the capture edge of the synchronized tmr_in: 00 none, 01 rising, 10 falling, 11 both. On a capture edge the capture register takes the count held before that clock edge, and event bit 0 sets. With 00, the capture register and event bit 0 are left unchanged.
- R8: Writing the event register clears each bit written as 1. An event in the same cycle as the clear keeps its bit set.
- R9: Mode bits [9:8] route the capture event and bits [11:10] route the reference event: 01 to interrupt, 10 to DMA, other values to neither. irq is high while a set event bit is routed to interrupt.
- R10: An event routed to DMA raises dreq in the next cycle. dreq then stays high until a cycle with dma_ack high, and a new DMA event wins over the acknowledge.
- R11: Writing the mode register stores the full word, which reads back unchanged. The same write clears the count, the prescaler phase and the output pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| tmr_in | input | 1 | Asynchronous timer pin: external clock and capture input |
| tmr_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request level |
| dreq | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge, clears dreq |

## Verification
A wrong prescaler phase or a wrong divide-by-sixteen phase shows up in the count register within one prescaler period, since the count read at every cycle is compared against a behavioural model. A wrong synchronizer depth or a wrong edge history shifts capture values and external ticks by at least one cycle, and the first pulse on tmr_in exposes it. A mis-held event flag or DMA state shows on irq or dreq in the cycle after the event or the acknowledge. An output-mode fault shows on tmr_out at the first reference match.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
   localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
   localparam logic [ADDR_W-1:0] A_CAPT = 3'd2;
   localparam logic [ADDR_W-1:0] A_EVT  = 3'd3;
   localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

   // mode word field positions
   localparam int unsigned F_EN   = 0;
   localparam int unsigned F_SRC  = 1;
   localparam int unsigned F_RST  = 3;
   localparam int unsigned F_OUT  = 4;
   localparam int unsigned F_EDGE = 6;
   localparam int unsigned F_CRT  = 8;
   localparam int unsigned F_RRT  = 10;
   localparam int unsigned F_PSC  = 12;

   typedef enum logic [1:0] {SRC_SYS, SRC_DIV, SRC_EXT, SRC_OFF} src_e;
   typedef enum logic [1:0] {OUT_NONE, OUT_PULSE, OUT_TOGGLE, OUT_RSVD} outm_e;
   typedef enum logic [1:0] {EDGE_OFF, EDGE_RISE, EDGE_FALL, EDGE_ANY} edge_e;
   typedef enum logic [1:0] {RT_NONE, RT_IRQ, RT_DMA, RT_RSVD} route_e;
endpackage

// File: rtl/capcmp_tickgen.sv
module capcmp_tickgen
   import capcmp_pkg::*;
#(
   parameter int unsigned PSC_W  = 8,
   parameter int unsigned DIV_W  = 4,
   parameter int unsigned SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  src_e             src,
   input  logic [PSC_W-1:0] psc,
   input  logic             pin,
   output logic             tick,
   output logic             pin_rise,
   output logic             pin_fall
);
   generate
      if (SYNC_N < 2) begin : g_bad_sync
         $error("capcmp_tickgen: SYNC_N must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("capcmp_tickgen: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0]  div_q;
   logic [SYNC_N-1:0] sync_q;
   logic              hist_q;
   logic [PSC_W-1:0]  pre_q;
   logic              src_tick;
   logic              synced;

   always_ff @(posedge clk) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n)      sync_q[i] <= 1'b0;
         else if (i == 0) sync_q[i] <= pin;
         else             sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
   end

   assign synced = sync_q[SYNC_N-1];

   always_ff @(posedge clk) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= synced;
   end

   assign pin_rise = synced & ~hist_q;
   assign pin_fall = ~synced & hist_q;

   always_comb begin
      unique case (src)
         SRC_SYS: src_tick = en;
         SRC_DIV: src_tick = en & (&div_q);
         SRC_EXT: src_tick = en & pin_rise;
         default: src_tick = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr)  pre_q <= '0;
      else if (src_tick)  pre_q <= (pre_q == psc) ? '0 : pre_q + 1'b1;
   end

   assign tick = src_tick & (pre_q == psc);
endmodule

// File: rtl/capcmp_core.sv
module capcmp_core
   import capcmp_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr,
   input  logic             restart,
   input  logic [CNT_W-1:0] ref_val,
   input  outm_e            out_mode,
   input  logic             cap_hit,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap_val,
   output logic             match,
   output logic             pin_out
);
   assign match = tick & (cnt == ref_val);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)        cnt <= '0;
      else if (tick)            cnt <= (match && restart) ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cap_val <= '0;
      else if (cap_hit) cap_val <= cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) pin_out <= 1'b0;
      else begin
         unique case (out_mode)
            OUT_PULSE:  if (tick)  pin_out <= match;
            OUT_TOGGLE: if (match) pin_out <= ~pin_out;
            default:    pin_out <= 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
   import capcmp_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned PSC_W  = 8,
   parameter int unsigned DIV_W  = 4,
   parameter int unsigned SYNC_N = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic [2:0]  rd_addr,
   output logic [31:0] rd_data,
   input  logic        tmr_in,
   output logic        tmr_out,
   input  logic        dma_ack,
   output logic        irq,
   output logic        dreq
);
   localparam int unsigned PAD_W = REG_W - CNT_W;

   generate
      if (CNT_W > REG_W || CNT_W < 2) begin : g_bad_cnt
         $error("capcmp_timer: CNT_W out of range");
      end
      if (F_PSC + PSC_W > REG_W) begin : g_bad_psc
         $error("capcmp_timer: prescaler field does not fit the mode word");
      end
   endgenerate

   logic [REG_W-1:0] mode_q;
   logic [CNT_W-1:0] ref_q;
   logic [1:0]       flag_q;
   logic             dreq_q;

   logic mode_wr, ref_wr, evt_wr;
   assign mode_wr = wr_en && (wr_addr == A_MODE);
   assign ref_wr  = wr_en && (wr_addr == A_REF);
   assign evt_wr  = wr_en && (wr_addr == A_EVT);

   logic   en, restart;
   src_e   src;
   outm_e  out_mode;
   edge_e  cap_edge;
   route_e cap_rt, ref_rt;
   logic [PSC_W-1:0] psc;

   assign en       = mode_q[F_EN];
   assign restart  = mode_q[F_RST];
   assign src      = src_e'(mode_q[F_SRC +: 2]);
   assign out_mode = outm_e'(mode_q[F_OUT +: 2]);
   assign cap_edge = edge_e'(mode_q[F_EDGE +: 2]);
   assign cap_rt   = route_e'(mode_q[F_CRT +: 2]);
   assign ref_rt   = route_e'(mode_q[F_RRT +: 2]);
   assign psc      = mode_q[F_PSC +: PSC_W];

   logic tick, pin_rise, pin_fall, cap_hit, match;
   logic [CNT_W-1:0] cnt, cap_val;

   capcmp_tickgen #(.PSC_W(PSC_W), .DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(en), .clr(mode_wr), .src(src), .psc(psc),
      .pin(tmr_in), .tick(tick), .pin_rise(pin_rise), .pin_fall(pin_fall)
   );

   always_comb begin
      unique case (cap_edge)
         EDGE_RISE: cap_hit = en & pin_rise;
         EDGE_FALL: cap_hit = en & pin_fall;
         EDGE_ANY:  cap_hit = en & (pin_rise | pin_fall);
         default:   cap_hit = 1'b0;
      endcase
   end

   capcmp_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(mode_wr), .restart(restart),
      .ref_val(ref_q), .out_mode(out_mode), .cap_hit(cap_hit),
      .cnt(cnt), .cap_val(cap_val), .match(match), .pin_out(tmr_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         ref_q  <= '0;
      end else begin
         if (mode_wr) mode_q <= wr_data;
         if (ref_wr)  ref_q  <= wr_data[CNT_W-1:0];
      end
   end

   logic [1:0] evt_set, evt_clr;
   assign evt_set = {match, cap_hit};
   assign evt_clr = evt_wr ? wr_data[1:0] : 2'b00;

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~evt_clr) | evt_set;
   end

   logic dma_set;
   assign dma_set = (cap_hit && cap_rt == RT_DMA) || (match && ref_rt == RT_DMA);

   always_ff @(posedge clk) begin
      if (!rst_n) dreq_q <= 1'b0;
      else        dreq_q <= dma_set | (dreq_q & ~dma_ack);
   end

   assign dreq = dreq_q;
   assign irq  = (flag_q[0] && cap_rt == RT_IRQ) || (flag_q[1] && ref_rt == RT_IRQ);

   always_comb begin
      unique case (rd_addr)
         A_MODE:  rd_data = mode_q;
         A_REF:   rd_data = {{PAD_W{1'b0}}, ref_q};
         A_CAPT:  rd_data = {{PAD_W{1'b0}}, cap_val};
         A_EVT:   rd_data = {30'd0, flag_q};
         A_CNT:   rd_data = {{PAD_W{1'b0}}, cnt};
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/capcmp_checker.sv
module capcmp_checker #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_wr,
   input logic             en,
   input logic [1:0]       src,
   input logic             restart,
   input logic [1:0]       out_mode,
   input logic             tick,
   input logic             match,
   input logic [CNT_W-1:0] cnt,
   input logic             tmr_out,
   input logic             irq,
   input logic [1:0]       flags,
   input logic             dreq,
   input logic             dma_ack
);
   // R4: count only steps by one or returns to zero
   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt) |-> (cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0));

   // R2: no source or disabled channel keeps the count still
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((!en || src == 2'b11) && !mode_wr) |=> $stable(cnt));

   // R5: restart mode zeroes the count after a match
   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (match && restart) |=> (cnt == '0));

   // R6: toggle mode flips the pin on a match
   p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (match && out_mode == 2'b10 && !mode_wr) |=> (tmr_out != $past(tmr_out)));

   // R6: pulse mode drops the pin on a tick without a match
   p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !match && out_mode == 2'b01) |=> !tmr_out);

   // R9: interrupt needs a pending event
   p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flags != 2'b00));

   // R10: request held until acknowledged
   p_dreq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq && !dma_ack) |=> dreq);
endmodule

bind capcmp_timer capcmp_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .en(en), .src(src),
   .restart(restart), .out_mode(out_mode), .tick(tick), .match(match),
   .cnt(cnt), .tmr_out(tmr_out), .irq(irq), .flags(flag_q), .dreq(dreq),
   .dma_ack(dma_ack)
);

// File: tb/tb_capcmp_timer.sv
`timescale 1ns/1ps
module tb_capcmp_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic        tmr_in = 1'b0;
   logic        dma_ack = 1'b0;
   logic [31:0] rd_data;
   logic        tmr_out, irq, dreq;

   always #2.5 clk = ~clk;

   capcmp_timer dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tmr_in(tmr_in), .tmr_out(tmr_out),
      .dma_ack(dma_ack), .irq(irq), .dreq(dreq)
   );

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_mode, m_ref, m_cap, m_cnt;
   logic [1:0]  m_flg;
   logic        m_out, m_dreq, m_s1, m_s2, m_s3;
   int          m_div, m_pre;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_ref = 0; m_cap = 0; m_cnt = 0; m_flg = 0;
         m_out = 0; m_dreq = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_div = 0; m_pre = 0;
      end else begin
         automatic bit en   = m_mode[0];
         automatic int src  = m_mode[2:1];
         automatic int psc  = m_mode[19:12];
         automatic int om   = m_mode[5:4];
         automatic int eg   = m_mode[7:6];
         automatic bit rise = m_s2 && !m_s3;
         automatic bit fall = !m_s2 && m_s3;
         automatic bit srct = en && (src == 0 || (src == 1 && m_div == 15) || (src == 2 && rise));
         automatic bit tk   = srct && (m_pre == psc);
         automatic bit mt   = tk && (m_cnt == m_ref);
         automatic bit ch   = en && ((eg == 1 && rise) || (eg == 2 && fall) || (eg == 3 && (rise || fall)));
         automatic bit dset = (ch && m_mode[9:8] == 2) || (mt && m_mode[11:10] == 2);
         if (ch) m_cap = m_cnt;
         if (srct) m_pre = (m_pre == psc) ? 0 : m_pre + 1;
         if (tk) m_cnt = (mt && m_mode[3]) ? 32'd0 : m_cnt + 1;
         if (om == 2) begin if (mt) m_out = !m_out; end
         else if (om == 1) begin if (tk) m_out = mt; end
         else m_out = 0;
         if (wr_en && wr_addr == 3) m_flg = m_flg & ~wr_data[1:0];
         m_flg = m_flg | {mt, ch};
         m_dreq = dset || (m_dreq && !dma_ack);
         if (wr_en && wr_addr == 0) begin
            m_mode = wr_data; m_cnt = 0; m_pre = 0; m_out = 0;
         end
         if (wr_en && wr_addr == 1) m_ref = wr_data;
         m_div = (m_div + 1) % 16;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = tmr_in;
      end
   end

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_mode;
         3'd1: return m_ref;
         3'd2: return m_cap;
         3'd3: return {30'd0, m_flg};
         3'd4: return m_cnt;
         default: return 32'd0;
      endcase
   endfunction

   // per-cycle comparison against the model, rotating the read address
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         automatic logic m_irq = (m_flg[0] && m_mode[9:8] == 2'd1) || (m_flg[1] && m_mode[11:10] == 2'd1);
         chk("R6 tmr_out vs model", {31'd0, tmr_out}, {31'd0, m_out});
         chk("R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
         chk("R10 dreq vs model", {31'd0, dreq}, {31'd0, m_dreq});
         case (rd_addr)
            3'd0: chk("R11 mode read vs model", rd_data, m_read(rd_addr));
            3'd1: chk("R5 ref read vs model", rd_data, m_read(rd_addr));
            3'd2: chk("R7 capture read vs model", rd_data, m_read(rd_addr));
            3'd3: chk("R8 event read vs model", rd_data, m_read(rd_addr));
            default: chk("R2 R3 R4 count read vs model", rd_data, m_read(rd_addr));
         endcase
         rd_addr = (rd_addr == 3'd4) ? 3'd0 : rd_addr + 3'd1;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic peek(input string tag, input logic [2:0] a, input logic [31:0] exp);
      rd_addr = a;
      #0.1;
      chk(tag, rd_data, exp);
   endtask

   task automatic pulse_in();
      @(negedge clk); tmr_in = 1'b1;
      repeat (3) @(negedge clk);
      tmr_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1.5;
      // R1: reset state
      for (int a = 0; a < 5; a++) peek("R1 register after reset", 3'(a), 32'd0);
      chk("R1 tmr_out after reset", {31'd0, tmr_out}, 32'd0);
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);
      chk("R1 dreq after reset", {31'd0, dreq}, 32'd0);

      // R3: system clock, prescale 3 -> one count per four clocks
      wr(3'd0, 32'h0000_3001);
      repeat (40) @(negedge clk); #1.5;
      peek("R3 count after 40 clocks with prescale 3", 3'd4, 32'd10);
      peek("R11 mode read back", 3'd0, 32'h0000_3001);

      // R5/R6: restart at reference 5, toggle output, reference to interrupt
      wr(3'd1, 32'd5);
      wr(3'd0, 32'h0000_0429);
      repeat (30) @(negedge clk); #1.5;
      peek("R5 restart count after five periods", 3'd4, 32'd0);
      chk("R6 toggle after five matches", {31'd0, tmr_out}, 32'd1);
      chk("R9 irq on routed reference event", {31'd0, irq}, 32'd1);

      // R11/R8: disable, then clear flags
      wr(3'd0, 32'd0);
      #1.5;
      peek("R11 count cleared by mode write", 3'd4, 32'd0);
      chk("R11 output cleared by mode write", {31'd0, tmr_out}, 32'd0);
      wr(3'd3, 32'd3);
      #1.5;
      peek("R8 event bits cleared", 3'd3, 32'd0);
      chk("R8 irq low after clear", {31'd0, irq}, 32'd0);

      // R10: reference 3, prescale 1, pulse output, reference to DMA
      wr(3'd1, 32'd3);
      wr(3'd0, 32'h0000_1811);
      for (int i = 0; i < 40 && !dreq; i++) @(negedge clk);
      #1.5;
      chk("R10 dreq raised by DMA-routed match", {31'd0, dreq}, 32'd1);
      chk("R9 irq stays low for DMA route", {31'd0, irq}, 32'd0);
      repeat (5) @(negedge clk); #1.5;
      chk("R10 dreq held without ack", {31'd0, dreq}, 32'd1);
      @(negedge clk); dma_ack = 1'b1;
      @(negedge clk); dma_ack = 1'b0; #1.5;
      chk("R10 dreq dropped after ack", {31'd0, dreq}, 32'd0);

      // R2/R7: external clock, capture on rising edge, capture to interrupt
      wr(3'd0, 32'd0);
      wr(3'd1, 32'hFFFF_0000);
      wr(3'd3, 32'd3);
      wr(3'd0, 32'h0000_0145);
      repeat (4) pulse_in();
      repeat (5) @(negedge clk); #1.5;
      peek("R2 count of external rising edges", 3'd4, 32'd4);
      peek("R7 rising capture holds count before edge", 3'd2, 32'd3);
      peek("R7 capture event bit set", 3'd3, 32'd1);
      chk("R9 irq on routed capture event", {31'd0, irq}, 32'd1);

      // R7: falling edge capture
      wr(3'd3, 32'd3);
      wr(3'd0, 32'h0000_0185);
      pulse_in();
      repeat (5) @(negedge clk); #1.5;
      peek("R7 falling capture", 3'd2, 32'd1);

      // R7: capture disabled leaves capture and flag untouched
      wr(3'd3, 32'd3);
      wr(3'd0, 32'h0000_0105);
      repeat (2) pulse_in();
      repeat (5) @(negedge clk); #1.5;
      peek("R7 disabled capture keeps value", 3'd2, 32'd1);
      peek("R7 disabled capture sets no flag", 3'd3, 32'd0);
      peek("R2 external ticks still counted", 3'd4, 32'd2);

      // R7: both edges
      wr(3'd0, 32'h0000_01C5);
      repeat (2) pulse_in();
      repeat (5) @(negedge clk); #1.5;
      peek("R7 any-edge capture", 3'd2, 32'd2);

      // R2: divide-by-16 source
      wr(3'd3, 32'd3);
      wr(3'd0, 32'h0000_0003);
      repeat (160) @(negedge clk); #1.5;
      peek("R2 divide-by-16 count after 160 clocks", 3'd4, 32'd10);

      // R2: no source selected
      wr(3'd0, 32'h0000_0007);
      repeat (20) @(negedge clk); #1.5;
      peek("R2 no source keeps count", 3'd4, 32'd0);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule